// File: doc/BRIEF.md
# Single-Accumulator Processor Core

This block is a small sequential processor built around one 16-bit accumulator. It fetches 16-bit instruction words from a 4096-word memory over a synchronous single-port interface and runs each one through a short state sequence: fetch, decode, an optional pointer lookup, then execute. The memory sits outside the core. A read returns its data on the cycle after the address is driven.

An instruction word holds three fields. Bit 15 is the mode flag: 0 means the low twelve bits are the operand address, and 1 means they point to a word that holds that address. Bits 14..12 are the opcode, and bits 11..0 are the address field. Opcode 7 does not use memory. With the mode flag clear it acts on the accumulator, and with the flag set it moves characters through an 8-bit input holding register and an 8-bit output register. Both of these registers use a valid/ready handshake. A halt operation freezes the core until the next reset.

Top module: `acc_core`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the core drives `mem_addr`=0 with `mem_we`=0, `halted`=0, `out_valid`=0, `in_ready`=1 and `carry`=0.
- R2: Each fetch reads the word at the program counter and advances the counter by one. The next fetch reads the following address unless a branch or skip changes it.
- R3: With bit 15 set on opcodes 0..6, the word at the address field is read first, and its low 12 bits become the effective address.
- R4: Opcode 0 ANDs the operand into the accumulator. Opcode 1 adds it, with the carry out going to `carry`. Opcode 2 loads it. The operand is always read from the effective address.
- R5: Opcode 3 writes the accumulator to the effective address.
- R6: Opcode 4 jumps to the effective address. Opcode 5 writes the address of the following instruction (zero-extended) to the effective address and then jumps to the effective address plus one.
- R7: Opcode 6 increments the word at the effective address and writes it back. When the result is zero, the next instruction is skipped.
- R8: Opcode 7 with bit 15 clear applies, in this order: clear (bit 11), complement (bit 9), increment (bit 5). These operations leave `carry` unchanged.
- R9: Opcode 7 with bit 15 set works as follows. Bit 11 copies the held input character into accumulator bits 7..0 and frees the holder. Bit 10 places accumulator bits 7..0 on `out_data` and raises `out_valid`, which stays high with stable data until `out_ready`. A character is accepted on `in_valid` while `in_ready` is high, and `in_ready` then stays low until the character is taken.
- R10: Opcode 7 with bit 15 clear and bit 0 set raises `halted`. After that, `halted` stays high and the core makes no further memory write.
- R11: The core takes read data from `mem_rdata` on the cycle after it drives the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 12 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write strobe for this cycle |
| mem_rdata | input | 16 | Read data for the address driven on the previous cycle |
| in_data | input | 8 | Character offered by the input device |
| in_valid | input | 1 | Input character present |
| in_ready | output | 1 | Input holder empty |
| out_data | output | 8 | Character for the output device |
| out_valid | output | 1 | Output character present |
| out_ready | input | 1 | Output device takes the character |
| carry | output | 1 | Carry out of the last add |
| halted | output | 1 | Core stopped |

## Verification
An instruction without a pointer takes two fetch cycles plus one to four execute cycles. Its memory write appears on the execute cycle that drives it: the first for a store or call, the fourth for increment-and-skip. The pointer lookup adds two cycles. The scoreboard does not predict the exact cycle of each write. It expects the stream of writes and output characters in program order and compares each one at the falling edge of the cycle in which the strobe is high. A write at a skipped address, or a write out of order, therefore appears as a mismatch, and so does a lost write. Checks on the input handshake and the output stall sample on the falling edge after the accepting or stalling rising edge.

// File: rtl/acc_core.sv
module acc_core #(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata,
  input  logic [CW-1:0] in_data,
  input  logic          in_valid,
  output logic          in_ready,
  output logic [CW-1:0] out_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          carry,
  output logic          halted
);
  localparam logic [2:0] OP_AND = 3'd0, OP_ADD = 3'd1, OP_LDA = 3'd2, OP_STA = 3'd3,
                         OP_BUN = 3'd4, OP_BSA = 3'd5, OP_ISZ = 3'd6, OP_REG = 3'd7;

  typedef enum logic [3:0] {S_F0, S_F1, S_I0, S_I1, S_X0, S_X1, S_X2, S_X3, S_HLT} st_t;
  st_t st;

  logic [AW-1:0] pc, ar;
  logic [DW-1:0] ac, dr, regv;
  logic [2:0]    op;
  logic          ind;
  logic [4:0]    fn;
  logic [CW-1:0] inpr;
  logic          in_full;
  logic          take_in, put_out, isz_zero;

  assign halted    = (st == S_HLT);
  assign in_ready  = !in_full;
  assign mem_addr  = (st == S_F0) ? pc : ar;
  assign mem_we    = (st == S_X0 && (op == OP_STA || op == OP_BSA)) ||
                     (st == S_X3 && op == OP_ISZ);
  assign mem_wdata = (op == OP_BSA) ? DW'(pc) : (op == OP_ISZ) ? dr : ac;
  assign take_in   = (st == S_X0) && op == OP_REG && ind && fn[4] && in_full;
  assign put_out   = (st == S_X0) && op == OP_REG && ind && fn[3] && !out_valid;
  assign isz_zero  = (dr == '0);

  always_comb begin
    regv = fn[4] ? '0 : ac;
    if (fn[2]) regv = ~regv;
    if (fn[1]) regv = regv + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_F0; pc <= '0; ar <= '0; ac <= '0; dr <= '0; carry <= 1'b0;
      op <= '0; ind <= 1'b0; fn <= '0; inpr <= '0; in_full <= 1'b0;
      out_data <= '0; out_valid <= 1'b0;
    end else begin
      if (in_valid && !in_full) begin
        inpr <= in_data;
        in_full <= 1'b1;
      end else if (take_in) begin
        in_full <= 1'b0;
      end
      if (put_out) begin
        out_data <= ac[CW-1:0];
        out_valid <= 1'b1;
      end else if (out_valid && out_ready) begin
        out_valid <= 1'b0;
      end

      case (st)
        S_F0: begin
          ar <= pc;
          pc <= pc + 1'b1;
          st <= S_F1;
        end
        S_F1: begin
          ind <= mem_rdata[DW-1];
          op  <= mem_rdata[14:12];
          fn  <= {mem_rdata[11], mem_rdata[10], mem_rdata[9], mem_rdata[5], mem_rdata[0]};
          ar  <= mem_rdata[AW-1:0];
          st  <= (mem_rdata[DW-1] && mem_rdata[14:12] != OP_REG) ? S_I0 : S_X0;
        end
        S_I0: st <= S_I1;
        S_I1: begin
          ar <= mem_rdata[AW-1:0];
          st <= S_X0;
        end
        S_X0: begin
          case (op)
            OP_STA: st <= S_F0;
            OP_BUN: begin pc <= ar; st <= S_F0; end
            OP_BSA: begin ar <= ar + 1'b1; st <= S_X1; end
            OP_REG: begin
              if (!ind) begin
                ac <= regv;
                st <= fn[0] ? S_HLT : S_F0;
              end else if (fn[4]) begin
                if (take_in) begin
                  ac[CW-1:0] <= inpr;
                  st <= S_F0;
                end
              end else if (fn[3]) begin
                if (put_out) st <= S_F0;
              end else begin
                st <= S_F0;
              end
            end
            default: st <= S_X1;
          endcase
        end
        S_X1: begin
          if (op == OP_BSA) begin
            pc <= ar;
            st <= S_F0;
          end else begin
            dr <= mem_rdata;
            st <= S_X2;
          end
        end
        S_X2: begin
          case (op)
            OP_AND: ac <= ac & dr;
            OP_ADD: {carry, ac} <= {1'b0, ac} + {1'b0, dr};
            OP_LDA: ac <= dr;
            default: dr <= dr + 1'b1;
          endcase
          st <= (op == OP_ISZ) ? S_X3 : S_F0;
        end
        S_X3: begin
          if (isz_zero) pc <= pc + 1'b1;
          st <= S_F0;
        end
        default: st <= S_HLT;
      endcase
    end
  end

  AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_F0) |=> (pc == AW'($past(pc) + 1'b1))); // R2
  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_I1) |=> (ar == $past(mem_rdata[AW-1:0]))); // R3
  AST_READ_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_X1 && op != OP_BSA) |=> (dr == $past(mem_rdata))); // R11
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted); // R10
  AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_we); // R10
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9
  AST_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R9
  AST_REG_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_X0 && op == OP_REG) |=> $stable(carry)); // R8
endmodule

// File: tb/tb_acc_core.sv
module tb_acc_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        mem_we;
  logic [7:0]  in_data = 8'h00, out_data;
  logic        in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0, carry, halted;

  always #2 clk = ~clk;

  acc_core dut (.*);

  logic [15:0] mem [4096];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  int checks = 0, errors = 0;
  logic [27:0] exp_wr[$];
  logic [7:0]  exp_ch[$];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_wr(logic [11:0] a, logic [15:0] d);
    exp_wr.push_back({a, d});
  endtask

  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_wr.size() == 0) chk("R5 unexpected write", {4'h0, mem_addr, mem_wdata}, 32'hFFFFFFFF);
      else begin
        logic [27:0] e;
        e = exp_wr.pop_front();
        chk("R5/R6/R7 write", {4'h0, mem_addr, mem_wdata}, {4'h0, e});
      end
    end
    if (rst_n && out_valid && out_ready) begin
      if (exp_ch.size() == 0) chk("R9 unexpected char", {24'h0, out_data}, 32'hFFFFFFFF);
      else chk("R9 char", {24'h0, out_data}, {24'h0, exp_ch.pop_front()});
    end
  end

  initial begin
    int cyc;
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
    mem[0]  = 16'h2064; mem[1]  = 16'h1065; mem[2]  = 16'h30C8; mem[3]  = 16'h8066;
    mem[4]  = 16'hB068; mem[5]  = 16'h7200; mem[6]  = 16'h7020; mem[7]  = 16'h30CA;
    mem[8]  = 16'h7A20; mem[9]  = 16'h30CB; mem[10] = 16'h6069; mem[11] = 16'h30CC;
    mem[12] = 16'h606A; mem[13] = 16'h512C; mem[14] = 16'h4010; mem[15] = 16'h30CE;
    mem[16] = 16'h7001;
    mem[301] = 16'h206B; mem[302] = 16'hF400; mem[303] = 16'hF800;
    mem[304] = 16'h30CD; mem[305] = 16'hC12C;
    mem[100] = 16'h00F5; mem[101] = 16'hFF20; mem[102] = 16'h0067; mem[103] = 16'h000C;
    mem[104] = 16'h00C9; mem[105] = 16'hFFFF; mem[106] = 16'h0005; mem[107] = 16'h0041;

    expect_wr(12'd200, 16'h0015); // R4 load + add
    expect_wr(12'd201, 16'h0004); // R3 indirect and/store
    expect_wr(12'd202, 16'hFFFC); // R8 complement then increment
    expect_wr(12'd203, 16'h0000); // R8 clear, complement, increment order
    expect_wr(12'd105, 16'h0000); // R7 wrap to zero, skip
    expect_wr(12'd106, 16'h0006); // R7 no skip
    expect_wr(12'd300, 16'h000E); // R6 return address
    expect_wr(12'd205, 16'h005A); // R9 input into low byte
    exp_ch.push_back(8'h41);

    in_data = 8'h5A;
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 addr", {20'h0, mem_addr}, 32'h0);
    chk("R1 we", {31'h0, mem_we}, 32'h0);
    chk("R1 halted", {31'h0, halted}, 32'h0);
    chk("R1 out_valid", {31'h0, out_valid}, 32'h0);
    chk("R1 in_ready", {31'h0, in_ready}, 32'h1);
    chk("R1 carry", {31'h0, carry}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 input held, in_ready low", {31'h0, in_ready}, 32'h0);
    in_valid = 1'b0;

    fork
      begin
        wait (out_valid);
        repeat (3) @(negedge clk);
        chk("R9 out_valid stalled", {31'h0, out_valid}, 32'h1);
        chk("R9 out_data stalled", {24'h0, out_data}, 32'h41);
        out_ready = 1'b1;
      end
    join_none

    cyc = 0;
    while (!halted && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    if (!halted) chk("R10 watchdog", 32'h0, 32'h1);
    else begin
      chk("R10 halted", {31'h0, halted}, 32'h1);
      repeat (10) begin
        @(negedge clk);
        chk("R10 stays halted, no write", {30'h0, halted, mem_we}, 32'h2);
      end
      chk("R4 carry from add", {31'h0, carry}, 32'h1);
      chk("R9 input freed", {31'h0, in_ready}, 32'h1);
      chk("R2 all writes seen", exp_wr.size(), 32'h0);
      chk("R9 all chars seen", exp_ch.size(), 32'h0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule